// File: doc/BRIEF.md
# Non-Overlapping Pulse Pattern Generator

This block drives an 8-bit output pattern that steps through a sequence set by software, with a dead-time guard between phases. A free-running counter runs from zero up to a period compare value and then clears; each clear is one step of the pattern. A second compare value, the guard margin, splits every step into two parts. Bits that fall in the new pattern drop at the period match. Bits that rise wait until the counter reaches the margin. As a result, two phases never overlap. Writing the repeating sequence 0x95, 0x65, 0x59, 0x56 produces four-phase complementary output suitable for stepping a motor.

Software writes the next pattern into a staging register. A flag, raised when the margin match occurs, marks the point where that write should be made. The flag drives an interrupt line when enabled and is cleared by writing a one. The outputs form two 4-bit groups. Each group can switch the guard off and take the whole new pattern at the period match. A per-bit enable mask freezes any bit that is not enabled.

Top module: `nov_pulse_gen`

## Requirements
- R1: While rst_n is low, pat_o, flag_o and irq_o are 0, the counter is 0 and the staging and latched patterns are 0.
- R2: While run_i is high, the counter advances by one per clock and is cleared to 0 in the cycle after it equals period_i (a period match). While run_i is low, it holds and no match occurs.
- R3: In a guarded group with margin_i < period_i, a period match sets each enabled bit to the AND of its current value and the staging value. Enabled bits may fall but never rise at that match.
- R4: With margin_i < period_i, a run cycle where the counter equals margin_i (a margin match) loads the enabled bits of guarded groups with the pattern latched at the last period match. This makes them rise margin_i+1 clocks after that period match.
- R5: When margin_i >= period_i, the margin match coincides with the period match, and every enabled bit takes the staging value at once.
- R6: nov_mode_i[0] guards bits 3:0 and nov_mode_i[1] guards bits 7:4. In a group whose bit is 0, enabled bits take the full staging value at the period match.
- R7: A bit whose out_en_i bit is 0 holds its value through every transfer.
- R8: The period match uses the staging value held before that clock edge. A stage_wr_i in the same cycle only affects the next period match.
- R9: A margin match sets flag_o in the next cycle. irq_o equals flag_o AND irq_en_i. A margin match wins over a clear in the same cycle.
- R10: flag_clr_i high in a cycle with no margin match clears flag_o in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run_i | input | 1 | Counter run enable |
| period_i | input | 16 | Period compare value |
| margin_i | input | 16 | Guard margin compare value |
| nov_mode_i | input | 2 | Per-group guard enable |
| out_en_i | input | 8 | Per-bit output enable |
| stage_wr_i | input | 1 | Staging register write strobe |
| stage_data_i | input | 8 | Staging write data |
| irq_en_i | input | 1 | Interrupt enable |
| flag_clr_i | input | 1 | Write-one-to-clear for the flag |
| pat_o | output | 8 | Pattern output |
| flag_o | output | 1 | Margin match flag |
| irq_o | output | 1 | Interrupt request |

## Verification
Two pairs of events can fall in the same cycle. A staging write can coincide with a period match. A flag clear can coincide with a margin match. The random phase writes patterns and pulses clears on random cycles, so both pairs come up. Each time, a behavioural model in the bench decides the result: the old staging value is transferred and the flag stays set. Every clock, the model's pattern and flag are compared with the outputs. The interrupt-driven phase walks the four-phase sequence with guard margins of zero, mid-period and beyond the period.

// File: rtl/nov_pulse_gen.sv
module nov_pulse_gen #(
  parameter int CNT_W = 16,
  parameter int GRP_W = 4,
  parameter int N_GRP = 2,
  localparam int PW = GRP_W * N_GRP
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  input  logic [CNT_W-1:0] period_i,
  input  logic [CNT_W-1:0] margin_i,
  input  logic [N_GRP-1:0] nov_mode_i,
  input  logic [PW-1:0]    out_en_i,
  input  logic             stage_wr_i,
  input  logic [PW-1:0]    stage_data_i,
  input  logic             irq_en_i,
  input  logic             flag_clr_i,
  output logic [PW-1:0]    pat_o,
  output logic             flag_o,
  output logic             irq_o
);

  logic [CNT_W-1:0] cnt_q;
  logic [PW-1:0]    stage_q;
  logic [PW-1:0]    next_q;
  logic [PW-1:0]    out_q;
  logic             flag_q;
  logic [PW-1:0]    nov_mask;
  logic [PW-1:0]    fall_mask;
  logic [PW-1:0]    step_val;
  logic [PW-1:0]    rise_en;
  logic             late;
  logic             period_hit;
  logic             margin_hit;

  for (genvar g = 0; g < N_GRP; g++) begin : g_grp
    assign nov_mask[g*GRP_W +: GRP_W] = {GRP_W{nov_mode_i[g]}};
  end

  assign late       = (margin_i >= period_i);
  assign period_hit = run_i && (cnt_q == period_i);
  assign margin_hit = run_i && (late ? (cnt_q == period_i) : (cnt_q == margin_i));
  assign fall_mask  = nov_mask & {PW{~late}};
  assign step_val   = stage_q & (out_q | ~fall_mask);
  assign rise_en    = out_en_i & nov_mask;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (run_i) begin
      cnt_q <= period_hit ? '0 : cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stage_q <= '0;
      next_q  <= '0;
      out_q   <= '0;
    end else begin
      if (stage_wr_i) stage_q <= stage_data_i;
      if (period_hit) begin
        next_q <= stage_q;
        out_q  <= (out_q & ~out_en_i) | (step_val & out_en_i);
      end else if (margin_hit) begin
        out_q  <= (out_q & ~rise_en) | (next_q & rise_en);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)          flag_q <= 1'b0;
    else if (margin_hit) flag_q <= 1'b1;
    else if (flag_clr_i) flag_q <= 1'b0;
  end

  assign pat_o  = out_q;
  assign flag_o = flag_q;
  assign irq_o  = flag_q & irq_en_i;

endmodule

module nov_pulse_gen_chk #(
  parameter int CNT_W = 16,
  parameter int PW = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             run_i,
  input logic [CNT_W-1:0] period_i,
  input logic [CNT_W-1:0] margin_i,
  input logic [CNT_W-1:0] cnt_q,
  input logic [PW-1:0]    nov_mask,
  input logic [PW-1:0]    out_en_i,
  input logic [PW-1:0]    pat_o,
  input logic             margin_hit,
  input logic             flag_clr_i,
  input logic             flag_o,
  input logic             irq_en_i,
  input logic             irq_o
);

  a_r2_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (run_i && cnt_q == period_i) |=> (cnt_q == '0));

  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !run_i |=> $stable(cnt_q));

  a_r3_no_rise: assert property (@(posedge clk) disable iff (!rst_n)
    (run_i && cnt_q == period_i && margin_i < period_i)
      |=> ((pat_o & ~$past(pat_o) & $past(nov_mask)) == '0));

  a_r7_masked: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (((pat_o ^ $past(pat_o)) & ~$past(out_en_i)) == '0));

  a_r9_set: assert property (@(posedge clk) disable iff (!rst_n)
    margin_hit |=> flag_o);

  a_r9_irq_gate: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_en_i |-> !irq_o);

  a_r10_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_clr_i && !margin_hit) |=> !flag_o);

endmodule

bind nov_pulse_gen nov_pulse_gen_chk #(.CNT_W(CNT_W), .PW(PW)) chk_i (
  .clk(clk), .rst_n(rst_n), .run_i(run_i), .period_i(period_i),
  .margin_i(margin_i), .cnt_q(cnt_q), .nov_mask(nov_mask),
  .out_en_i(out_en_i), .pat_o(pat_o), .margin_hit(margin_hit),
  .flag_clr_i(flag_clr_i), .flag_o(flag_o), .irq_en_i(irq_en_i),
  .irq_o(irq_o)
);

// File: tb/nov_pulse_gen_tb.sv
module nov_pulse_gen_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        run_i = 1'b0;
  logic [15:0] period_i = 16'd0;
  logic [15:0] margin_i = 16'd0;
  logic [1:0]  nov_mode_i = 2'b00;
  logic [7:0]  out_en_i = 8'h00;
  logic        stage_wr_i = 1'b0;
  logic [7:0]  stage_data_i = 8'h00;
  logic        irq_en_i = 1'b0;
  logic        flag_clr_i = 1'b0;
  logic [7:0]  pat_o;
  logic        flag_o;
  logic        irq_o;

  int n_checks = 0;
  int n_fail = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  nov_pulse_gen dut_i (
    .clk(clk), .rst_n(rst_n), .run_i(run_i), .period_i(period_i),
    .margin_i(margin_i), .nov_mode_i(nov_mode_i), .out_en_i(out_en_i),
    .stage_wr_i(stage_wr_i), .stage_data_i(stage_data_i),
    .irq_en_i(irq_en_i), .flag_clr_i(flag_clr_i),
    .pat_o(pat_o), .flag_o(flag_o), .irq_o(irq_o)
  );

  // behavioural reference model
  int         m_cnt;
  logic [7:0] m_out, m_stage, m_next, m_nov, m_new;
  logic       m_flag;
  bit         m_ph, m_mh, m_late;
  string      m_tag, m_ftag;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 0; m_out = 0; m_stage = 0; m_next = 0; m_flag = 0;
      m_tag = "R1"; m_ftag = "R1";
    end else begin
      m_late = (margin_i >= period_i);
      m_ph   = run_i && (m_cnt == int'(period_i));
      m_mh   = run_i && (m_late ? m_ph : (m_cnt == int'(margin_i)));
      m_nov  = {{4{nov_mode_i[1]}}, {4{nov_mode_i[0]}}};
      m_tag  = run_i ? "R2" : "R7";
      if (m_ph) begin
        for (int b = 0; b < 8; b++) begin
          if (out_en_i[b]) begin
            if (m_nov[b] && !m_late) m_new[b] = m_out[b] & m_stage[b];
            else m_new[b] = m_stage[b];
          end else m_new[b] = m_out[b];
        end
        m_out  = m_new;
        m_next = m_stage;
        m_tag  = m_late ? "R5" : ((m_nov != 8'hFF) ? "R6" : "R3");
      end else if (m_mh) begin
        for (int b = 0; b < 8; b++)
          if (out_en_i[b] && m_nov[b]) m_out[b] = m_next[b];
        m_tag = "R4";
      end
      if (stage_wr_i) begin
        m_stage = stage_data_i;
        if (m_ph) m_tag = "R8";
      end
      m_ftag = "R9";
      if (m_mh) m_flag = 1'b1;
      else if (flag_clr_i) begin m_flag = 1'b0; m_ftag = "R10"; end
      if (run_i) m_cnt = m_ph ? 0 : m_cnt + 1;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    #2;
    if (!done) begin
      check(pat_o == m_out, {m_tag, " pattern"}, pat_o, m_out);
      check(flag_o == m_flag, {m_ftag, " flag"}, flag_o, m_flag);
      check(irq_o == (m_flag & irq_en_i), "R9 irq", irq_o, m_flag & irq_en_i);
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 50000 && !done) begin
      done = 1'b1;
      n_checks++; n_fail++;
      $display("FAIL watchdog actual=%0d expected<=%0d", cycles, 50000);
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

  logic [7:0] seq [4] = '{8'h95, 8'h65, 8'h59, 8'h56};

  task automatic run_case(input int per, input int mar, input logic [1:0] nov,
                          input logic [7:0] en, input bit ien, input int ncyc,
                          input bit rnd);
    int k = 1;
    @(negedge clk);
    rst_n = 1'b0; run_i = 1'b0; stage_wr_i = 1'b0; flag_clr_i = 1'b0;
    period_i = 16'(per); margin_i = 16'(mar); nov_mode_i = nov;
    out_en_i = en; irq_en_i = ien;
    repeat (2) @(negedge clk);
    check(pat_o == 8'h00 && flag_o == 1'b0 && irq_o == 1'b0, "R1 reset",
          {pat_o, flag_o, irq_o}, 0);
    rst_n = 1'b1;
    stage_wr_i = 1'b1; stage_data_i = seq[0];
    @(negedge clk);
    stage_wr_i = 1'b0; run_i = 1'b1;
    for (int c = 0; c < ncyc; c++) begin
      @(negedge clk);
      stage_wr_i = 1'b0; flag_clr_i = 1'b0;
      if (rnd) begin
        if ($urandom_range(0, 3) == 0) begin
          stage_wr_i = 1'b1; stage_data_i = 8'($urandom_range(0, 255));
        end
        if ($urandom_range(0, 4) == 0) flag_clr_i = 1'b1;
        if ($urandom_range(0, 15) == 0) run_i = ~run_i;
        if ($urandom_range(0, 20) == 0) out_en_i = 8'($urandom_range(0, 255));
      end else if (flag_o) begin
        stage_wr_i = 1'b1; stage_data_i = seq[k]; flag_clr_i = 1'b1;
        k = (k + 1) % 4;
      end
    end
    @(negedge clk);
    run_i = 1'b0; stage_wr_i = 1'b0; flag_clr_i = 1'b0;
  endtask

  initial begin
    run_case(9, 3, 2'b11, 8'hFF, 1'b1, 120, 1'b0);
    run_case(7, 0, 2'b11, 8'hFF, 1'b1, 80, 1'b0);
    run_case(6, 12, 2'b11, 8'hFF, 1'b0, 60, 1'b0);
    run_case(5, 2, 2'b01, 8'h3C, 1'b1, 300, 1'b1);
    run_case(4, 1, 2'b10, 8'hFF, 1'b1, 400, 1'b1);
    run_case(3, 3, 2'b11, 8'hF0, 1'b0, 200, 1'b1);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule